// File: doc/BRIEF.md
# Write-Protected Pin Function Controller

This block holds the pin multiplexing state for a large group of pins. Each pin has two settings. One select bit routes the pin to its peripheral (1) or leaves it as GPIO (0). One 4-bit code picks which of sixteen alternate peripheral functions drives the pin. Both kinds of settings are packed into 32-bit banks on a plain memory-mapped bus. Software changes a setting by reading the bank, editing one bit or one field, and writing the whole word back.

Every write to a select or function bank is guarded. The write counts only if the bus write just before it went to the key register and carried the bitwise inverse of the data now being written. One unlock allows exactly one write, and any following bus write uses it up. A guarded write that fails the check is dropped and raises a sticky error flag. Reading the status word clears that flag.

The bus is a single-cycle control port with no back-pressure. A write is taken on the clock edge where `wr_en` is high. `rdata` follows `addr` combinationally while `rd_en` is high. A read of the status word clears the flag on the edge where `rd_en` is high.

Top module: `pfc_top`

## Requirements
- R1: After reset every select bank and function bank holds zero, so `periph_en` and `func_code` are all zero, and the error flag is clear.
- R2: Reads are never guarded and return the contents in the same cycle. Offset 0x000 (key) reads zero. Offset 0x004 (status) returns the error flag in bit 0. Select bank b is at 0x100+4b (b < SEL_BANKS) and function bank b is at 0x200+4b (b < FN_BANKS). Every other offset, including any offset with address bits [1:0] not equal to zero, reads zero.
- R3: A write of D to a select or function bank lands if and only if the previous bus write was to the key with value ~D. Idle cycles between the two writes are allowed. The new value shows on the outputs one cycle after the write.
- R4: A guarded write whose data differs from the complement of the stored key is dropped: the bank keeps its old value and the error flag is set.
- R5: An unlock is single-use. A second guarded write after one unlock is dropped and sets the error flag.
- R6: A new key write replaces any pending unlock. Only the latest key value can authorise the next write.
- R7: A write to an unmapped offset or to the status word consumes a pending unlock and changes no register.
- R8: A guarded write with no pending unlock is dropped and sets the error flag.
- R9: The error flag is sticky. It stays set until a status read clears it on that read's clock edge, and the read itself returns 1.
- R10: `periph_en[32*b+n]` equals bit n of select bank b. A value of 1 means peripheral and 0 means GPIO.
- R11: `func_code[32*b+4*f +: 4]` equals bits [4f+3:4f] of function bank b, for fields f = 0..7.
- R12: A read of a bank in the same cycle as an accepted write to that bank returns the old value. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| rd_en | input | 1 | Read strobe; clears the error flag when addressing the status word |
| addr | input | ADDR_W (12) | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| periph_en | output | 32*SEL_BANKS (256) | Per-pin peripheral select bits |
| func_code | output | 32*FN_BANKS (608) | Per-pin 4-bit alternate function codes |

## Verification
Two functions can act on the same bank in one cycle: an accepted guarded write and a read of that bank. The bench provokes this by raising `rd_en` and `wr_en` together on the same address right after an unlock. It then checks that the read returns the old word, and that a read one cycle later returns the new word. A second check covers the key and the guard logic together. After two back-to-back key writes, data matching the older key must be rejected and data matching the newer key accepted. The result of each case is judged both through `rdata` and directly on the `periph_en` and `func_code` pins.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 4;
  localparam int IDX_W   = 6;

  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_KEY,
    DEC_STAT,
    DEC_SEL,
    DEC_FN
  } dec_kind_t;

  typedef struct packed {
    dec_kind_t         kind;
    logic [IDX_W-1:0]  bank;
  } dec_t;
endpackage

// File: rtl/pfc_addr_decode.sv
module pfc_addr_decode
  import pfc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SEL_BANKS = 8,
  parameter int FN_BANKS  = 19
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;

  assign page = addr[ADDR_W-1:8];
  assign idx  = addr[7:2];

  always_comb begin
    dec.kind = DEC_NONE;
    dec.bank = idx;
    if (addr[1:0] == 2'b00) begin
      if (page == PAGE_W'(0)) begin
        if (idx == IDX_W'(0))      dec.kind = DEC_KEY;
        else if (idx == IDX_W'(1)) dec.kind = DEC_STAT;
      end else if (page == PAGE_W'(1)) begin
        if (32'(idx) < SEL_BANKS)  dec.kind = DEC_SEL;
      end else if (page == PAGE_W'(2)) begin
        if (32'(idx) < FN_BANKS)   dec.kind = DEC_FN;
      end
    end
  end
endmodule

// File: rtl/pfc_unlock.sv
module pfc_unlock
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_key,
  input  logic [DATA_W-1:0] wdata,
  output logic              grant,
  output logic              armed,
  output logic [DATA_W-1:0] key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      key_q <= '0;
    end else if (wr_en) begin
      if (is_key) begin
        armed <= 1'b1;
        key_q <= wdata;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  assign grant = armed && (wdata == ~key_q);
endmodule

// File: rtl/pfc_bank_array.sv
module pfc_bank_array
  import pfc_pkg::*;
#(
  parameter int NBANKS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NBANKS*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] regs [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[b] <= '0;
      else if (we && idx == IDX_W'(b))     regs[b] <= wdata;
    end
    assign flat[b*DATA_W +: DATA_W] = regs[b];
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (idx == IDX_W'(b)) rd_data = regs[b];
    end
  end
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SEL_BANKS = 8,
  parameter int FN_BANKS  = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [SEL_BANKS*32-1:0]     periph_en,
  output logic [FN_BANKS*32-1:0]      func_code
);
  dec_t              dec;
  logic              grant;
  logic              armed;
  logic [DATA_W-1:0] key_q;
  logic              err_q;
  logic              guarded;
  logic              sel_we;
  logic              fn_we;
  logic [DATA_W-1:0] sel_rd;
  logic [DATA_W-1:0] fn_rd;

  pfc_addr_decode #(
    .ADDR_W(ADDR_W), .SEL_BANKS(SEL_BANKS), .FN_BANKS(FN_BANKS)
  ) u_dec (
    .addr(addr), .dec(dec)
  );

  pfc_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .is_key(dec.kind == DEC_KEY), .wdata(wdata),
    .grant(grant), .armed(armed), .key_q(key_q)
  );

  assign guarded = wr_en && (dec.kind == DEC_SEL || dec.kind == DEC_FN);
  assign sel_we  = wr_en && grant && dec.kind == DEC_SEL;
  assign fn_we   = wr_en && grant && dec.kind == DEC_FN;

  pfc_bank_array #(.NBANKS(SEL_BANKS)) u_sel (
    .clk(clk), .rst_n(rst_n), .we(sel_we), .idx(dec.bank),
    .wdata(wdata), .rd_data(sel_rd), .flat(periph_en)
  );

  pfc_bank_array #(.NBANKS(FN_BANKS)) u_fn (
    .clk(clk), .rst_n(rst_n), .we(fn_we), .idx(dec.bank),
    .wdata(wdata), .rd_data(fn_rd), .flat(func_code)
  );

  // Sticky reject flag: a new reject wins over a clearing read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              err_q <= 1'b0;
    else if (guarded && !grant)              err_q <= 1'b1;
    else if (rd_en && dec.kind == DEC_STAT)  err_q <= 1'b0;
  end

  always_comb begin
    unique case (dec.kind)
      DEC_STAT: rdata = {31'b0, err_q};
      DEC_SEL:  rdata = sel_rd;
      DEC_FN:   rdata = fn_rd;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int ADDR_W    = 12,
  parameter int SEL_BANKS = 8,
  parameter int FN_BANKS  = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wdata,
  input logic [31:0]             rdata,
  input logic [SEL_BANKS*32-1:0] periph_en,
  input logic [FN_BANKS*32-1:0]  func_code,
  input logic                    armed,
  input logic [31:0]             key_q,
  input logic                    err
);
  logic key_hit, stat_hit, sel_hit, fn_hit, prot_hit;
  assign key_hit  = (32'(addr) == 32'h000);
  assign stat_hit = (32'(addr) == 32'h004);
  assign sel_hit  = (addr[1:0] == 2'b00) && (32'(addr) >= 32'h100) &&
                    (32'(addr) < 32'h100 + 4 * SEL_BANKS);
  assign fn_hit   = (addr[1:0] == 2'b00) && (32'(addr) >= 32'h200) &&
                    (32'(addr) < 32'h200 + 4 * FN_BANKS);
  assign prot_hit = sel_hit || fn_hit;

  a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && key_hit) |-> (rdata == 32'h0));

  a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_hit && !(armed && wdata == ~key_q)) |=> err);

  a_r5_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_hit) |=> !armed);

  a_r6_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_hit) |=> (armed && key_q == $past(wdata)));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_hit) |=> !err);

  a_r3_sel_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(periph_en) |-> $past(wr_en && sel_hit && armed));

  a_r3_fn_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_code) |-> $past(wr_en && fn_hit && armed));
endmodule

bind pfc_top pfc_checker #(
  .ADDR_W(ADDR_W), .SEL_BANKS(SEL_BANKS), .FN_BANKS(FN_BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .periph_en(periph_en), .func_code(func_code),
  .armed(armed), .key_q(key_q), .err(err_q)
);

// File: tb/tb_pfc_top.sv
`timescale 1ns/1ps
module tb_pfc_top;
  localparam int ADDR_W = 12;
  localparam int SEL_BANKS = 8;
  localparam int FN_BANKS = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [SEL_BANKS*32-1:0] pe;
  logic [FN_BANKS*32-1:0] fc;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfc_top #(.ADDR_W(ADDR_W), .SEL_BANKS(SEL_BANKS), .FN_BANKS(FN_BANKS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .periph_en(pe), .func_code(fc)
  );

  localparam logic [ADDR_W-1:0] A_KEY  = 12'h000;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h004;
  function automatic logic [ADDR_W-1:0] a_sel(input int b); return 12'h100 + 12'(4*b); endfunction
  function automatic logic [ADDR_W-1:0] a_fn(input int b);  return 12'h200 + 12'(4*b); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pwr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr(A_KEY, ~d);
    wr(a, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(a_sel(0), v);      chk("R1 sel0 reset", v, 32'h0);
    rd(a_fn(18), v);      chk("R1 fn18 reset", v, 32'h0);
    rd(A_STAT, v);        chk("R1 err reset", v, 32'h0);
    chk("R1 periph_en zero", 32'(|pe), 32'h0);
    chk("R1 func_code zero", 32'(|fc), 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_KEY, 32'h1234_5678);
    rd(A_KEY, v);         chk("R2 key reads zero", v, 32'h0);
    rd(12'h008, v);       chk("R2 unmapped 0x008", v, 32'h0);
    pwr(a_sel(7), 32'hFFFF_0001);
    rd(a_sel(7), v);      chk("R2 last sel bank", v, 32'hFFFF_0001);
    rd(12'h120, v);       chk("R2 sel bank past end", v, 32'h0);
    rd(12'h24C, v);       chk("R2 fn bank past end", v, 32'h0);
    rd(12'h11D, v);       chk("R2 unaligned", v, 32'h0);
  endtask

  task automatic t_accept;
    logic [31:0] v;
    wr(A_KEY, ~32'hA5A5_0F0F);
    repeat (3) @(negedge clk);
    wr(a_sel(3), 32'hA5A5_0F0F);
    chk("R3 R10 periph_en bank3", pe[3*32 +: 32], 32'hA5A5_0F0F);
    rd(a_sel(3), v);      chk("R3 sel3 readback", v, 32'hA5A5_0F0F);
    chk("R10 pin 3*32+0 peripheral", 32'(pe[96]), 32'h1);
    chk("R10 pin 3*32+4 gpio", 32'(pe[100]), 32'h0);
    rd(A_STAT, v);        chk("R3 no error", v, 32'h0);
  endtask

  task automatic t_fn;
    logic [31:0] v;
    pwr(a_fn(0), 32'hFEDC_BA98);
    chk("R11 fn0 field0", 32'(fc[0 +: 4]), 32'h8);
    chk("R11 fn0 field7", 32'(fc[28 +: 4]), 32'hF);
    rd(a_fn(18), v);
    v = (v & ~(32'hF << 28)) | (32'hC << 28);
    pwr(a_fn(18), v);
    chk("R11 fn18 field7", 32'(fc[18*32 + 28 +: 4]), 32'hC);
    chk("R11 fn18 field0 untouched", 32'(fc[18*32 +: 4]), 32'h0);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    wr(A_KEY, ~32'h0000_00FF ^ 32'h1);
    wr(a_sel(3), 32'h0000_00FF);
    chk("R4 sel3 unchanged", pe[3*32 +: 32], 32'hA5A5_0F0F);
    rd(A_STAT, v);        chk("R4 R9 error set", v, 32'h1);
    rd(A_STAT, v);        chk("R9 error cleared by read", v, 32'h0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    wr(A_KEY, ~32'h0F0F_1111);
    wr(a_sel(1), 32'h0F0F_1111);
    wr(a_sel(2), 32'h0F0F_1111);
    chk("R5 first write lands", pe[1*32 +: 32], 32'h0F0F_1111);
    chk("R5 second write dropped", pe[2*32 +: 32], 32'h0);
    rd(A_STAT, v);        chk("R5 error set", v, 32'h1);
  endtask

  task automatic t_rekey;
    logic [31:0] v;
    wr(A_KEY, ~32'hAAAA_0000);
    wr(A_KEY, ~32'hBBBB_0000);
    wr(a_sel(4), 32'hAAAA_0000);
    chk("R6 old key rejected", pe[4*32 +: 32], 32'h0);
    rd(A_STAT, v);        chk("R6 old key error", v, 32'h1);
    wr(A_KEY, ~32'hAAAA_0000);
    wr(A_KEY, ~32'hBBBB_0000);
    wr(a_sel(4), 32'hBBBB_0000);
    chk("R6 new key accepted", pe[4*32 +: 32], 32'hBBBB_0000);
  endtask

  task automatic t_cancel;
    logic [31:0] v;
    wr(A_KEY, ~32'h5555_0005);
    wr(12'h050, 32'h5555_0005);
    wr(a_sel(5), 32'h5555_0005);
    chk("R7 unmapped write cancels", pe[5*32 +: 32], 32'h0);
    rd(A_STAT, v);        chk("R7 error after cancel", v, 32'h1);
    wr(A_KEY, ~32'h5555_0005);
    wr(A_STAT, 32'h5555_0005);
    rd(A_STAT, v);        chk("R7 status write no effect", v, 32'h0);
    wr(a_fn(5), 32'h5555_0005);
    chk("R7 status write cancels", fc[5*32 +: 32], 32'h0);
  endtask

  task automatic t_nokey;
    logic [31:0] v;
    rd(A_STAT, v);
    wr(a_sel(6), 32'h0000_0042);
    chk("R8 no unlock dropped", pe[6*32 +: 32], 32'h0);
    rd(A_STAT, v);        chk("R8 error set", v, 32'h1);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(A_KEY, ~32'h1357_9BDF);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = a_sel(0); wdata = 32'h1357_9BDF;
    #1 v = rdata;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 same-cycle read old", v, 32'h0);
    rd(a_sel(0), v);      chk("R12 next read new", v, 32'h1357_9BDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_accept();
    t_fn();
    t_mismatch();
    t_single();
    t_rekey();
    t_cancel();
    t_nokey();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule